// File: doc/BRIEF.md
# Conditional Branch Resolver with Delay-Slot Squash

This unit settles a conditional branch that has one delay slot behind it. It receives the branch word, the integer condition flags and a valid strobe. It holds the address of the instruction being resolved as internal state. In the same cycle it reports whether the branch is taken, the PC-relative destination, and whether the delay-slot instruction must be squashed.

On a valid strobe it advances its pair of fetch addresses: the address of the next instruction to run and the one after it. Every resolved branch that is taken raises a one-cycle event output, and every squash raises a second one.

The unit sits between decode and fetch. The front end keeps presenting the word that lives at `pc_o` and asserts `valid_i` when that word is a branch. The unit does not fetch instructions. It does not flush anything beyond the squash indication. It has no floating-point branches.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0, `npc_o` is 4, and both event outputs are 0.
- R2: The condition is word bits 28..25, and the flags are packed {N,Z,V,C} in bits 3..0. Codes 0 to 7 are taken as follows:
  - 0: never
  - 1: Z
  - 2: Z|(N^V)
  - 3: N^V
  - 4: C|Z
  - 5: C
  - 6: N
  - 7: V
- R3: Code 8 is always taken. Codes 9 to 15 take the logical inverse of codes 1 to 7 respectively.
- R4: `target_o` equals `pc_o` plus the low 22 bits of the word, sign-extended from bit 21 and multiplied by 4, modulo 2^32.
- R5: Bit 29 is the annul bit. A branch that is not taken, with annul set, squashes the delay slot. At the next clock `pc_o` becomes old `pc_o`+8 and `npc_o` becomes old `pc_o`+12.
- R6: A branch that is not taken, with annul clear, does not squash. At the next clock `pc_o` becomes old `pc_o`+4 and `npc_o` becomes old `pc_o`+8.
- R7: Code 8 with annul set squashes the delay slot. At the next clock `pc_o` becomes the target and `npc_o` becomes target+4.
- R8: Any other taken branch does not squash, including a taken conditional with annul set. At the next clock `pc_o` becomes old `pc_o`+4 and `npc_o` becomes the target.
- R9: While `valid_i` is low, `pc_o` and `npc_o` hold their values whatever the word and the flags are. Both event outputs are 0 one clock later.
- R10: One clock after a valid branch, `taken_evt_o` equals that branch's taken result and `squash_evt_o` equals its squash result. Each event lasts one cycle unless another valid branch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | The word at `pc_o` is a branch to resolve |
| inst_i | input | 32 | Branch instruction word |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | 32 | PC-relative destination |
| squash_o | output | 1 | Delay-slot instruction is to be annulled |
| pc_o | output | 32 | Address of the instruction to execute now |
| npc_o | output | 32 | Address of the instruction after that |
| taken_evt_o | output | 1 | One-cycle pulse for a taken branch |
| squash_evt_o | output | 1 | One-cycle pulse for a squashed delay slot |

## Verification
The bench crosses all sixteen condition codes with all sixteen flag combinations and both annul settings. This shows whether each code reads the right flags and whether each upper code is the exact inverse of its lower partner. The same sweep also separates the four next-address paths: untaken with annul, untaken plain, always-with-annul, and taken otherwise. Its key case is a taken conditional branch with annul set, which must still run its slot.

Displacements vary across the sweep, and the extremes are checked on their own: the largest positive value, the most negative value, zero and -1. These show sign extension and the ×4 scaling. Idle cycles with changing words and flags show that state is held without a strobe.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
package bru_pkg;
  localparam int unsigned INST_W = 32;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [3:0] {
    CC_NEVER = 4'h0, CC_EQ  = 4'h1, CC_LE  = 4'h2, CC_LT  = 4'h3,
    CC_LEU   = 4'h4, CC_CS  = 4'h5, CC_NEG = 4'h6, CC_VS  = 4'h7,
    CC_ALWAYS= 4'h8, CC_NE  = 4'h9, CC_GT  = 4'hA, CC_GE  = 4'hB,
    CC_GTU   = 4'hC, CC_CC  = 4'hD, CC_POS = 4'hE, CC_VC  = 4'hF
  } cond_e;
endpackage

// File: rtl/bru_cond_eval.sv
`timescale 1ns/1ps
module bru_cond_eval
  import bru_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       taken_o
);
  logic [7:0] base;

  // lower half; upper half is its bitwise inverse (code 8 = ~never)
  always_comb begin
    base[0] = 1'b0;
    base[1] = flags_i.z;
    base[2] = flags_i.z | (flags_i.n ^ flags_i.v);
    base[3] = flags_i.n ^ flags_i.v;
    base[4] = flags_i.c | flags_i.z;
    base[5] = flags_i.c;
    base[6] = flags_i.n;
    base[7] = flags_i.v;
  end

  assign taken_o = base[cond_i[2:0]] ^ cond_i[3];
endmodule

// File: rtl/bru_target_calc.sv
`timescale 1ns/1ps
module bru_target_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 22
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
    end else begin : g_noext
      assign offset = {disp_i[ADDR_W-3:0], 2'b00};
    end
  endgenerate

  assign target_o = pc_i + offset;
endmodule

// File: rtl/bru_next_pc.sv
`timescale 1ns/1ps
module bru_next_pc #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              taken_i,
  input  logic              annul_i,
  input  logic              always_i,
  output logic              squash_o,
  output logic [ADDR_W-1:0] pc_nxt_o,
  output logic [ADDR_W-1:0] npc_nxt_o
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(12);

  always_comb begin
    if (!taken_i) begin
      squash_o  = annul_i;
      pc_nxt_o  = annul_i ? pc_i + STEP2 : pc_i + STEP1;
      npc_nxt_o = annul_i ? pc_i + STEP3 : pc_i + STEP2;
    end else if (annul_i && always_i) begin
      squash_o  = 1'b1;
      pc_nxt_o  = target_i;
      npc_nxt_o = target_i + STEP1;
    end else begin
      // taken conditional keeps its slot even with annul set
      squash_o  = 1'b0;
      pc_nxt_o  = pc_i + STEP1;
      npc_nxt_o = target_i;
    end
  end

  // R7
  always_comb begin
    ba_annul_squash_chk: assert (!(taken_i && annul_i && always_i) || squash_o);
  end
endmodule

// File: rtl/branch_resolve_unit.sv
`timescale 1ns/1ps
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       inst_i,
  input  logic [3:0]        flags_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              squash_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o,
  output logic              taken_evt_o,
  output logic              squash_evt_o
);
  localparam int unsigned ANNUL_BIT = 29;
  localparam int unsigned COND_LSB  = 25;
  localparam logic [ADDR_W-1:0] RST_NPC = ADDR_W'(4);

  logic [3:0]        cond;
  logic              annul;
  logic              is_always;
  flags_t            flg;
  logic [ADDR_W-1:0] pc_q, npc_q, pc_nxt, npc_nxt;
  logic              taken_evt_q, squash_evt_q;
  logic              unused_bits;

  assign cond        = inst_i[COND_LSB+3:COND_LSB];
  assign annul       = inst_i[ANNUL_BIT];
  assign is_always   = (cond == CC_ALWAYS);
  assign flg         = flags_t'(flags_i);
  assign unused_bits = ^{inst_i[31:30], inst_i[COND_LSB-1:DISP_W]};

  bru_cond_eval u_cond (
    .cond_i  (cond),
    .flags_i (flg),
    .taken_o (taken_o)
  );

  bru_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i     (pc_q),
    .disp_i   (inst_i[DISP_W-1:0]),
    .target_o (target_o)
  );

  bru_next_pc #(.ADDR_W(ADDR_W)) u_npc (
    .pc_i      (pc_q),
    .target_i  (target_o),
    .taken_i   (taken_o),
    .annul_i   (annul),
    .always_i  (is_always),
    .squash_o  (squash_o),
    .pc_nxt_o  (pc_nxt),
    .npc_nxt_o (npc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q         <= '0;
      npc_q        <= RST_NPC;
      taken_evt_q  <= 1'b0;
      squash_evt_q <= 1'b0;
    end else begin
      taken_evt_q  <= valid_i & taken_o;
      squash_evt_q <= valid_i & squash_o;
      if (valid_i) begin
        pc_q  <= pc_nxt;
        npc_q <= npc_nxt;
      end
    end
  end

  assign pc_o         = pc_q;
  assign npc_o        = npc_q;
  assign taken_evt_o  = taken_evt_q;
  assign squash_evt_o = squash_evt_q;

  // R3
  never_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond[2:0] == 3'd0) |-> (taken_o == cond[3]));

  // R5
  nt_annul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !taken_o && annul) |=>
      (pc_o == $past(pc_o) + ADDR_W'(8)) && squash_evt_o);

  // R6
  nt_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !taken_o && !annul) |=>
      (pc_o == $past(pc_o) + ADDR_W'(4)) && (npc_o == $past(pc_o) + ADDR_W'(8)) && !squash_evt_o);

  // R7
  ba_annul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && annul && is_always) |=> (pc_o == $past(target_o)) && squash_evt_o);

  // R8
  taken_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && taken_o && !(annul && is_always)) |=>
      (npc_o == $past(target_o)) && !squash_evt_o && taken_evt_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pc_o) && $stable(npc_o) && !taken_evt_o && !squash_evt_o);
endmodule

// File: tb/sim_branch_resolve_unit.sv
`timescale 1ns/1ps
module sim_branch_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] inst = '0;
  logic [3:0]  flags = '0;
  logic        taken, squash, tevt, sevt;
  logic [31:0] target, pc, npc;
  logic [31:0] exp_pc, exp_npc;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  branch_resolve_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .inst_i(inst), .flags_i(flags),
    .taken_o(taken), .target_o(target), .squash_o(squash), .pc_o(pc), .npc_o(npc),
    .taken_evt_o(tevt), .squash_evt_o(sevt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // flags {N,Z,V,C}
  function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (cc)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return c | z;
      4'd5:  return c;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(c | z);
      4'd13: return !c;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  task automatic run_br(input logic [3:0] cc, input logic an, input logic [21:0] d, input logic [3:0] f);
    logic        e_take, e_sq;
    logic [31:0] tgt, n_pc, n_npc;
    int          sd;
    string       tag;
    @(negedge clk);
    inst  = {2'b10, an, cc, 3'b010, d};
    flags = f;
    valid = 1'b1;
    #1;
    e_take = cond_ref(cc, f);
    sd     = d[21] ? (int'(d) - 4194304) : int'(d);
    tgt    = exp_pc + 32'(sd * 4);
    if (!e_take && an) begin
      tag = "R5"; e_sq = 1'b1; n_pc = exp_pc + 8; n_npc = exp_pc + 12;
    end else if (!e_take) begin
      tag = "R6"; e_sq = 1'b0; n_pc = exp_pc + 4; n_npc = exp_pc + 8;
    end else if (an && cc == 4'd8) begin
      tag = "R7"; e_sq = 1'b1; n_pc = tgt; n_npc = tgt + 4;
    end else begin
      tag = "R8"; e_sq = 1'b0; n_pc = exp_pc + 4; n_npc = tgt;
    end
    chk(cc[3] ? "R3 taken" : "R2 taken", {31'd0, taken}, {31'd0, e_take});
    chk("R4 target", target, tgt);
    chk({tag, " squash"}, {31'd0, squash}, {31'd0, e_sq});
    @(posedge clk);
    #1;
    valid = 1'b0;
    exp_pc = n_pc; exp_npc = n_npc;
    chk({tag, " pc"}, pc, exp_pc);
    chk({tag, " npc"}, npc, exp_npc);
    chk("R10 taken_evt", {31'd0, tevt}, {31'd0, e_take});
    chk("R10 squash_evt", {31'd0, sevt}, {31'd0, e_sq});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inst  = {2'b10, 1'b1, 4'd8, 3'b010, 22'(k * 977 + 5)};
      flags = 4'(k);
      @(posedge clk);
      #1;
      chk("R9 pc hold", pc, exp_pc);
      chk("R9 npc hold", npc, exp_npc);
      chk("R9 no taken_evt", {31'd0, tevt}, 32'd0);
      chk("R9 no squash_evt", {31'd0, sevt}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk("R1 pc", pc, 32'd0);
    chk("R1 npc", npc, 32'd4);
    chk("R1 evt", {30'd0, tevt, sevt}, 32'd0);
    rst_n = 1'b1;
    exp_pc = 32'd0; exp_npc = 32'd4;
    idle(2);

    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        for (int an = 0; an < 2; an++)
          run_br(4'(cc), an[0], 22'(cc * 4099 + f * 131 + an * 7) ^ 22'h155555, 4'(f));

    // R4 displacement extremes
    run_br(4'd8, 1'b0, 22'h1FFFFF, 4'h0);
    run_br(4'd8, 1'b0, 22'h200000, 4'h0);
    run_br(4'd8, 1'b1, 22'h000000, 4'h0);
    run_br(4'd8, 1'b1, 22'h3FFFFF, 4'h0);
    // R8 taken conditional with annul keeps slot; R5 never with annul
    run_br(4'd1, 1'b1, 22'h000010, 4'b0100);
    run_br(4'd0, 1'b1, 22'h000010, 4'b1111);
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule